// File: doc/BRIEF.md
# Banked Edge/Level Interrupt Controller

This block collects 64 interrupt request lines into two banks of 32 and presents one interrupt output to the processor. Each input first passes through a two-flop synchronizer. Lines picked by a per-bank level mask are level-sensitive: they are taken live from the synchronized input and are never stored. All other lines are edge-sensitive: a rising edge sets a sticky event bit, and that bit stays set until software writes a 1 to the matching acknowledge bit.

A line is pending when it is enabled and either its event bit is set or it is a level line whose input is high. The processor interrupt is a registered OR of all pending lines. A vector register gives the number of the highest-numbered pending line, so the upper bank always wins over the lower bank. Software works through a word-addressed register port. Data is little-endian: data bit 0 belongs to the lowest line of the addressed bank.

Top module: `pic_banked_ctrl`

## Requirements
- R1: After reset, every enable bit and every event bit reads 0, `irq_o` is 0, and the vector register reads 0.
- R2: Lines whose bit is set in the bank's level mask (default 0x1FF00000 for both banks, that is bits 20 to 28) never set their event bit. While enabled, such a line is pending exactly while its synchronized input is high.
- R3: A write to an acknowledge register clears each event bit whose data bit is 1. Bits written as 0 are unchanged. If a new edge arrives in the same cycle as the acknowledge, the event bit stays set. Reading an acknowledge register returns 0.
- R4: Reading an enable register returns the value last written to it. The write takes effect at the clock edge that ends the write cycle.
- R5: On an edge line, the event bit sets at the third clock edge after the input rises, because the input passes through two synchronizer flops. This happens whatever the enable setting. Enabling a line whose input is already high does not set its event bit.
- R6: `irq_o` is 1 in the cycle after any line is pending, and 0 in the cycle after no line is pending.
- R7: The vector register holds the number of the highest-numbered pending line in bits 5:0 and a 1 in bit 31. When nothing is pending it reads 0. Bank 1 holds lines 32 to 63 and bank 0 holds lines 0 to 31.
- R8: Word addresses map as follows. 0 is the vector. Bank 1 (lines 32-63) sits at words 4 to 7 and bank 0 (lines 0-31) at words 8 to 11. Within a bank the order is event, enable, acknowledge, level. The level register shows the synchronized input of every line, whatever the enable setting. Unmapped words read 0.
- R9: Writes to the vector, event and level registers, or to unmapped words, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines_i | input | 64 | Raw interrupt request lines, bit n is line n |
| bus_addr_i | input | 4 | Word address of the register port |
| bus_we_i | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
Several properties are checked on every cycle:
- Level-masked lines never hold an event bit.
- An event bit rises only after a synchronized rising edge.
- Acknowledged bits clear unless a new edge arrives in the same cycle.
- The enable register captures each write.
- The vector marks a pending line with no higher pending line above it.
- `irq_o` follows the vector's valid flag one cycle later.

Other behaviour can only be shown by the bench's scenarios, where a cycle-accurate reference model is compared on every clock. These scenarios cover:
- the three-edge latency through the synchronizer;
- the priority of bank 1 over bank 0;
- a disabled line that latches an edge and is later enabled;
- enabling a line whose input is already high;
- an acknowledge that lands in the same cycle as a new edge;
- writes to read-only words that must leave state unchanged.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int BANK_W   = 32;
  localparam int NBANK    = 2;
  localparam int LINES    = BANK_W * NBANK;
  localparam int ID_W     = $clog2(LINES);
  localparam int ADDR_W   = 4;
  localparam int VLD_BIT  = 31;

  localparam logic [ADDR_W-1:0] A_VECTOR  = 4'd0;
  localparam logic [ADDR_W-1:0] A_BANK_HI = 4'd4;
  localparam logic [ADDR_W-1:0] A_BANK_LO = 4'd8;

  localparam logic [ADDR_W-1:0] OFS_EVT = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_EN  = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_ACK = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_LVL = 4'd3;

  function automatic logic [ADDR_W-1:0] bank_base(input int b);
    return (b == 0) ? A_BANK_LO : A_BANK_HI;
  endfunction
endpackage

// File: rtl/pic_bank.sv
module pic_bank #(
  parameter int            W          = 32,
  parameter logic [W-1:0]  LEVEL_MASK = 32'h1FF0_0000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] line_i,
  input  logic         en_we_i,
  input  logic         ack_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] event_o,
  output logic [W-1:0] enable_o,
  output logic [W-1:0] level_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [W-1:0] event_q, event_d;
  logic [W-1:0] enable_q, enable_d;
  logic [W-1:0] rise;

  // edge lines only: synchronized rise, independent of enable
  always_comb begin
    rise     = sync_q & ~prev_q & ~LEVEL_MASK;
    event_d  = event_q;
    if (ack_we_i) event_d = event_d & ~wdata_i;
    event_d  = event_d | rise;
    enable_d = en_we_i ? wdata_i : enable_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q   <= '0;
      sync_q   <= '0;
      prev_q   <= '0;
      event_q  <= '0;
      enable_q <= '0;
    end else begin
      meta_q   <= line_i;
      sync_q   <= meta_q;
      prev_q   <= sync_q;
      event_q  <= event_d;
      enable_q <= enable_d;
    end
  end

  assign event_o  = event_q;
  assign enable_o = enable_q;
  assign level_o  = sync_q;
  assign pend_o   = (event_q | (sync_q & LEVEL_MASK)) & enable_q;

  // R2: level-sensitive lines never hold a latched event
  a_r2_level_not_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_q & LEVEL_MASK) == '0);

  // R3: acknowledged bits are clear next cycle unless a fresh edge came in
  a_r3_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_we_i |=> ((event_q & $past(wdata_i) & ~$past(rise)) == '0));

  // R5: an event bit only rises after a synchronized rising edge
  a_r5_set_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((event_q & ~$past(event_q) & ~($past(sync_q) & ~$past(prev_q))) == '0));

  // R4: enable captures the written word
  a_r4_enable_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> (enable_o == $past(wdata_i)));
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N   = 64,
  parameter int IDW = $clog2(N)
) (
  input  logic [N-1:0]   pend_i,
  output logic           valid_o,
  output logic [IDW-1:0] id_o
);
  // ascending scan: the last hit, the highest-numbered line, wins
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i]) begin
        valid_o = 1'b1;
        id_o    = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_banked_ctrl.sv
module pic_banked_ctrl
  import pic_pkg::*;
#(
  parameter logic [BANK_W-1:0] LVL_MASK_LO = 32'h1FF0_0000,
  parameter logic [BANK_W-1:0] LVL_MASK_HI = 32'h1FF0_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINES-1:0]  irq_lines_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [NBANK-1:0][BANK_W-1:0] evt_w, en_w, lvl_w, pend_w;
  logic [LINES-1:0]             pend_all;
  logic                         vec_vld;
  logic [ID_W-1:0]              vec_id;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] BASE = bank_base(b);
    localparam logic [BANK_W-1:0] MASK = (b == 0) ? LVL_MASK_LO : LVL_MASK_HI;
    logic en_we, ack_we;
    assign en_we  = bus_we_i && (bus_addr_i == BASE + OFS_EN);
    assign ack_we = bus_we_i && (bus_addr_i == BASE + OFS_ACK);

    pic_bank #(.W(BANK_W), .LEVEL_MASK(MASK)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_n_int),
      .line_i   (irq_lines_i[b*BANK_W +: BANK_W]),
      .en_we_i  (en_we),
      .ack_we_i (ack_we),
      .wdata_i  (bus_wdata_i),
      .event_o  (evt_w[b]),
      .enable_o (en_w[b]),
      .level_o  (lvl_w[b]),
      .pend_o   (pend_w[b])
    );
  end

  assign pend_all = pend_w;

  pic_prio #(.N(LINES), .IDW(ID_W)) u_prio (
    .pend_i  (pend_all),
    .valid_o (vec_vld),
    .id_o    (vec_id)
  );

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_VECTOR) begin
      bus_rdata_o[VLD_BIT]    = vec_vld;
      bus_rdata_o[ID_W-1:0]   = vec_id;
    end
    for (int b = 0; b < NBANK; b++) begin
      if (bus_addr_i == bank_base(b) + OFS_EVT) bus_rdata_o = evt_w[b];
      if (bus_addr_i == bank_base(b) + OFS_EN)  bus_rdata_o = en_w[b];
      if (bus_addr_i == bank_base(b) + OFS_LVL) bus_rdata_o = lvl_w[b];
    end
  end

  // registered interrupt output
  logic irq_d, irq_q;
  always_comb irq_d = |pend_all;

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end
  assign irq_o = irq_q;

  // R6: output follows the encoder's valid flag one cycle later
  a_r6_irq_on: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    vec_vld |=> irq_o);
  a_r6_irq_off: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !vec_vld |=> !irq_o);

  // R7: reported line is pending and nothing above it is
  a_r7_vector_top: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    vec_vld |-> ((pend_all >> vec_id) == LINES'(1)));
endmodule

// File: tb/pic_banked_ctrl_tb.sv
module pic_banked_ctrl_tb;
  localparam int CLK_P = 10;
  localparam logic [63:0] MASK = {32'h1FF0_0000, 32'h1FF0_0000};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] lines = '0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  pic_banked_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines),
    .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  logic [63:0] m_s1, m_s2, m_prev, m_evt, m_en;
  logic        m_irq;
  int          rcnt;

  function automatic logic [63:0] m_pend();
    return (m_evt | (m_s2 & MASK)) & m_en;
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a);
    logic [63:0] p = m_pend();
    logic [31:0] v = 0;
    case (a)
      4'd0: for (int i = 0; i < 64; i++) if (p[i]) v = 32'h8000_0000 | i;
      4'd4: v = m_evt[63:32];
      4'd5: v = m_en[63:32];
      4'd7: v = m_s2[63:32];
      4'd8: v = m_evt[31:0];
      4'd9: v = m_en[31:0];
      4'd11: v = m_s2[31:0];
      default: v = 0;
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_evt <= 0; m_en <= 0;
      m_irq <= 0; rcnt <= 0;
    end else if (rcnt < 2) begin
      rcnt <= rcnt + 1;
    end else begin
      logic [63:0] ackm;
      logic [63:0] en_n;
      ackm = 0;
      en_n = m_en;
      if (we && addr == 4'd6)  ackm[63:32] = wdata;
      if (we && addr == 4'd10) ackm[31:0]  = wdata;
      if (we && addr == 4'd5)  en_n[63:32] = wdata;
      if (we && addr == 4'd9)  en_n[31:0]  = wdata;
      m_s1   <= lines;
      m_s2   <= m_s1;
      m_prev <= m_s2;
      m_evt  <= (m_evt & ~ackm) | (m_s2 & ~m_prev & ~MASK);
      m_en   <= en_n;
      m_irq  <= |m_pend();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #(CLK_P/4);
    chk("R6 irq vs model", {31'd0, irq}, {31'd0, m_irq});
    chk("R8 read vs model", rdata, m_read(addr));
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = 4'd0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    #1 d = rdata;
  endtask

  task automatic rchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic raise(input int n);
    @(negedge clk); lines[n] = 1'b1;
  endtask

  task automatic lower(input int n);
    @(negedge clk); lines[n] = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    rchk("R1 enable lo", 4'd9, 32'h0);
    rchk("R1 event hi", 4'd4, 32'h0);
    rchk("R1 vector", 4'd0, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R4 enable readback
    wr(4'd9, 32'h0000_00F0);
    rchk("R4 enable readback", 4'd9, 32'h0000_00F0);

    // R5/R7/R6 edge on line 5
    raise(5); tick(5); lower(5);
    rchk("R5 edge latched", 4'd8, 32'h0000_0020);
    rchk("R7 vector line 5", 4'd0, 32'h8000_0005);
    chk("R6 irq high", {31'd0, irq}, 32'h1);

    // R5 disabled line 40 still latches; R7 upper bank wins once enabled
    raise(40); tick(5);
    rchk("R5 disabled edge latched", 4'd4, 32'h0000_0100);
    rchk("R7 disabled not reported", 4'd0, 32'h8000_0005);
    wr(4'd5, 32'h0000_0100); tick(1);
    rchk("R7 upper bank wins", 4'd0, 32'h8000_0028);

    // R3 acknowledge semantics
    wr(4'd6, 32'h0);
    rchk("R3 zero ack no effect", 4'd4, 32'h0000_0100);
    wr(4'd6, 32'h0000_0100);
    rchk("R3 ack clears", 4'd4, 32'h0);
    rchk("R3 ack reads zero", 4'd6, 32'h0);
    rchk("R7 back to line 5", 4'd0, 32'h8000_0005);

    // R2 level line 20
    raise(20); tick(5);
    rchk("R2 level not latched", 4'd8, 32'h0000_0020);
    rchk("R8 level lo raw", 4'd11, 32'h0010_0000);
    rchk("R8 level hi raw", 4'd7, 32'h0000_0100);
    wr(4'd9, 32'h0010_00F0); tick(1);
    rchk("R2 level pending", 4'd0, 32'h8000_0014);
    lower(20); tick(4);
    rchk("R2 level released", 4'd0, 32'h8000_0005);

    // R5 enabling an already-high edge line
    raise(3); tick(5);
    rchk("R5 line 3 latched", 4'd8, 32'h0000_0028);
    wr(4'd10, 32'h0000_0008);
    rchk("R3 line 3 acked", 4'd8, 32'h0000_0020);
    wr(4'd9, 32'h0010_00F8); tick(3);
    rchk("R5 enable on high no event", 4'd8, 32'h0000_0020);
    rchk("R5 enable on high no vector", 4'd0, 32'h8000_0005);

    // R9 writes to read-only words
    wr(4'd8, 32'hFFFF_FFFF);
    rchk("R9 event write ignored", 4'd8, 32'h0000_0020);
    wr(4'd11, 32'hFFFF_FFFF);
    rchk("R9 level write ignored", 4'd11, 32'h0000_0008);
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd13, 32'hFFFF_FFFF);
    rchk("R9 enable untouched", 4'd9, 32'h0010_00F8);
    rchk("R9 vector untouched", 4'd0, 32'h8000_0005);

    // R3 ack in same cycle as a new edge: set wins
    raise(6); tick(5); lower(6); tick(3);
    rchk("R7 line 6 wins", 4'd0, 32'h8000_0006);
    @(negedge clk); lines[6] = 1'b1;
    tick(2);
    addr = 4'd10; wdata = 32'h0000_0040; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = 4'd0;
    rchk("R3 edge beats ack", 4'd8, 32'h0000_0060);

    // clear everything
    wr(4'd10, 32'hFFFF_FFFF);
    wr(4'd6, 32'hFFFF_FFFF);
    rchk("R7 nothing pending", 4'd0, 32'h0);
    tick(1);
    chk("R6 irq low", {31'd0, irq}, 32'h0);

    // R8 unmapped words
    rchk("R8 unmapped 1", 4'd1, 32'h0);
    rchk("R8 unmapped 15", 4'd15, 32'h0);

    tick(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule